// File: doc/BRIEF.md
# Half-Flash Conversion Sequencer

This block is the digital timing and control core of a two-step 8-bit converter. A single bank of 15 comparators is shared by two flash phases. In the coarse phase the comparators see the held input against the full-span ladder, and the block encodes their thermometer word into the upper nibble. That nibble goes out to a residue DAC. In the fine phase the comparators see the residue instead, and the block encodes the lower nibble from them. The comparators, the DAC and the analog multiplexer sit outside the block.

A conversion begins when the active-low write strobe falls while the block is idle. At that point the block latches the channel address into a one-hot select and asserts the track/hold hold request. The upper nibble is copied into the result register only once the write strobe has returned high. The fine phase then runs, the lower nibble is stored, and the active-low done strobe falls in the same cycle that hold is released. Each phase lasts a parameterised number of clock cycles, and the comparator word is sampled on the last cycle of the phase.

Top module: `hf_conv_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears result, dacCode, chanSel, bubbleErr, holdEn and fineSel to zero, and drives doneN high.
- R2: A falling wrN sampled while idle starts a conversion: one clock edge later holdEn is 1 and doneN is 1, including when doneN was low from the previous conversion.
- R3: The coarse phase lasts COARSE_CYCLES clock cycles after the start edge. The comparator word is encoded on its last cycle, so dacCode takes the new upper nibble exactly COARSE_CYCLES edges after the start edge. dacCode does not change during the fine phase.
- R4: result[7:4] takes the coarse nibble only at the first clock edge where wrN is sampled high after the coarse phase. While wrN stays low, result is unchanged, and at the load edge result[3:0] still holds the previous value.
- R5: The fine phase lasts FINE_CYCLES edges after the upper-nibble load. At its last edge result[3:0] takes the fine nibble, doneN goes low, and holdEn goes low. doneN stays low until the next start.
- R6: The result is straight binary: for a held input level L (0..255, in units of span/256), the comparator model gives coarse code L>>4 and fine code L-16*dacCode, and the final result equals L.
- R7: chanSel is the one-hot decode of chanAddr sampled at the start edge (bit k set for address k) and is held for the whole conversion. Later address changes have no effect. Address 7 is the internal full-scale channel and converts to 255.
- R8: The thermometer encoder returns the number of asserted comparators for a monotonic word (bit i set implies bit i-1 set). For any other word it returns the highest asserted index plus one and sets bubbleErr. bubbleErr then stays set until the next start.
- R9: A wrN falling edge during a conversion is ignored. The conversion completes on its normal schedule, and no new conversion starts afterwards (holdEn stays 0).
- R10: fineSel, which selects the residue comparison, is 1 exactly during the fine phase and only while holdEn is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrN | input | 1 | Active-low write strobe; falling edge starts, rising edge releases the upper nibble |
| chanAddr | input | 3 | Channel address, sampled at the start |
| thermo | input | 15 | Thermometer word from the shared comparator bank |
| chanSel | output | 8 | One-hot select for the analog multiplexer |
| fineSel | output | 1 | 1 while the comparators must see the residue |
| dacCode | output | 4 | Upper nibble driven to the residue DAC |
| holdEn | output | 1 | Track/hold: 1 = hold, 0 = track |
| result | output | 8 | Conversion result register |
| doneN | output | 1 | Active-low end-of-conversion |
| bubbleErr | output | 1 | Non-monotonic comparator word seen in the current conversion |

## Verification
The hardest case to reach is a non-monotonic comparator word, because a consistent analog model never produces one. The bench therefore overrides the comparator word in one chosen phase, with a word whose population count and highest set bit give different codes. The other hard case is the window between the end of the coarse phase and the write release. A directed conversion holds wrN low well past the coarse phase, samples result before and after the release, and pulses wrN again during the fine phase. Every level on every channel is also swept, with the write-low time varied so that the release lands both before and after the coarse phase ends.

// File: rtl/hf_seq_pkg.sv
package hf_seq_pkg;
  typedef struct packed {
    logic startConv;
    logic capCoarse;
    logic loadMsb;
    logic capFine;
  } hfStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COARSE,
    ST_WAITWR,
    ST_FINE
  } hfState_t;
endpackage

// File: rtl/hf_therm_encoder.sv
module hf_therm_encoder #(
  parameter int NIB_BITS = 4,
  localparam int CMP_N = (1 << NIB_BITS) - 1
) (
  input  logic [CMP_N-1:0]    thermo,
  output logic [NIB_BITS-1:0] code,
  output logic                bubble
);
  logic [NIB_BITS-1:0] popCnt;
  logic [NIB_BITS-1:0] topIdx;
  logic [CMP_N-1:0]    gapBit;

  // A gap is an asserted comparator whose lower neighbour is clear
  assign gapBit[0] = 1'b0;
  for (genvar g = 1; g < CMP_N; g++) begin : g_gap
    assign gapBit[g] = thermo[g] & ~thermo[g-1];
  end

  always_comb begin
    popCnt = '0;
    topIdx = '0;
    for (int i = 0; i < CMP_N; i++) begin
      if (thermo[i]) begin
        popCnt = popCnt + 1'b1;
        topIdx = NIB_BITS'(i + 1);
      end
    end
  end

  assign bubble = |gapBit;
  assign code   = bubble ? topIdx : popCnt;
endmodule

// File: rtl/hf_seq_ctrl.sv
module hf_seq_ctrl
  import hf_seq_pkg::*;
#(
  parameter int COARSE_CYCLES = 4,
  parameter int FINE_CYCLES   = 3,
  localparam int MAX_CYC = (COARSE_CYCLES > FINE_CYCLES) ? COARSE_CYCLES : FINE_CYCLES,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrN,
  output hfStrobes_t strb,
  output logic       holdEn,
  output logic       doneN,
  output logic       fineSel
);
  hfState_t         state;
  logic [CNT_W-1:0] phaseCnt;
  logic             wrPrev;
  logic             startEv, lastCoarse, lastFine;

  assign startEv    = (state == ST_IDLE) && wrPrev && !wrN;
  assign lastCoarse = (state == ST_COARSE) && (phaseCnt == CNT_W'(COARSE_CYCLES - 1));
  assign lastFine   = (state == ST_FINE) && (phaseCnt == CNT_W'(FINE_CYCLES - 1));

  always_comb begin
    strb.startConv = startEv;
    strb.capCoarse = lastCoarse;
    strb.loadMsb   = (state == ST_WAITWR) && wrN;
    strb.capFine   = lastFine;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      wrPrev   <= 1'b1;
      holdEn   <= 1'b0;
      doneN    <= 1'b1;
      fineSel  <= 1'b0;
    end else begin
      wrPrev <= wrN;
      unique case (state)
        ST_IDLE: if (startEv) begin
          state    <= ST_COARSE;
          phaseCnt <= '0;
          holdEn   <= 1'b1;
          doneN    <= 1'b1;
        end
        ST_COARSE: begin
          if (lastCoarse) begin
            state    <= ST_WAITWR;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_WAITWR: if (wrN) begin
          state    <= ST_FINE;
          phaseCnt <= '0;
          fineSel  <= 1'b1;
        end
        ST_FINE: begin
          if (lastFine) begin
            state   <= ST_IDLE;
            holdEn  <= 1'b0;
            doneN   <= 1'b0;
            fineSel <= 1'b0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hf_seq_dp.sv
module hf_seq_dp
  import hf_seq_pkg::*;
#(
  parameter int NIB_BITS = 4,
  parameter int CHANNELS = 8,
  localparam int CMP_N    = (1 << NIB_BITS) - 1,
  localparam int RES_BITS = 2 * NIB_BITS,
  localparam int ADDR_W   = $clog2(CHANNELS)
) (
  input  logic                clk,
  input  logic                rst,
  input  hfStrobes_t          strb,
  input  logic [CMP_N-1:0]    thermo,
  input  logic [ADDR_W-1:0]   chanAddr,
  output logic [CHANNELS-1:0] chanSel,
  output logic [NIB_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] result,
  output logic                bubbleErr
);
  logic [NIB_BITS-1:0] encCode;
  logic                encBubble;
  logic [CHANNELS-1:0] selNext;

  hf_therm_encoder #(.NIB_BITS(NIB_BITS)) u_enc (
    .thermo(thermo),
    .code  (encCode),
    .bubble(encBubble)
  );

  for (genvar g = 0; g < CHANNELS; g++) begin : g_dec
    assign selNext[g] = (chanAddr == ADDR_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chanSel   <= '0;
      dacCode   <= '0;
      result    <= '0;
      bubbleErr <= 1'b0;
    end else begin
      if (strb.startConv) begin
        chanSel   <= selNext;
        bubbleErr <= 1'b0;
      end
      if (strb.capCoarse) begin
        dacCode <= encCode;
        if (encBubble) bubbleErr <= 1'b1;
      end
      if (strb.loadMsb) result[RES_BITS-1:NIB_BITS] <= dacCode;
      if (strb.capFine) begin
        result[NIB_BITS-1:0] <= encCode;
        if (encBubble) bubbleErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hf_conv_seq.sv
module hf_conv_seq
  import hf_seq_pkg::*;
#(
  parameter int NIB_BITS      = 4,
  parameter int CHANNELS      = 8,
  parameter int COARSE_CYCLES = 4,
  parameter int FINE_CYCLES   = 3,
  localparam int CMP_N    = (1 << NIB_BITS) - 1,
  localparam int RES_BITS = 2 * NIB_BITS,
  localparam int ADDR_W   = $clog2(CHANNELS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrN,
  input  logic [ADDR_W-1:0]   chanAddr,
  input  logic [CMP_N-1:0]    thermo,
  output logic [CHANNELS-1:0] chanSel,
  output logic                fineSel,
  output logic [NIB_BITS-1:0] dacCode,
  output logic                holdEn,
  output logic [RES_BITS-1:0] result,
  output logic                doneN,
  output logic                bubbleErr
);
  hfStrobes_t strb;

  hf_seq_ctrl #(
    .COARSE_CYCLES(COARSE_CYCLES),
    .FINE_CYCLES  (FINE_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wrN    (wrN),
    .strb   (strb),
    .holdEn (holdEn),
    .doneN  (doneN),
    .fineSel(fineSel)
  );

  hf_seq_dp #(
    .NIB_BITS(NIB_BITS),
    .CHANNELS(CHANNELS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .thermo   (thermo),
    .chanAddr (chanAddr),
    .chanSel  (chanSel),
    .dacCode  (dacCode),
    .result   (result),
    .bubbleErr(bubbleErr)
  );
endmodule

// File: rtl/hf_conv_seq_chk.sv
module hf_conv_seq_chk #(
  parameter int NIB_BITS    = 4,
  parameter int CHANNELS    = 8,
  parameter int FINE_CYCLES = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wrN,
  input logic                  doneN,
  input logic                  holdEn,
  input logic                  fineSel,
  input logic [NIB_BITS-1:0]   dacCode,
  input logic [2*NIB_BITS-1:0] result,
  input logic [CHANNELS-1:0]   chanSel
);
  int fineRun;

  always_ff @(posedge clk) begin
    if (rst) fineRun <= 0;
    else if (fineSel) fineRun <= fineRun + 1;
    else fineRun <= 0;
  end

  // R2
  start_done_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(holdEn) |-> doneN);

  // R5
  hold_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !doneN |-> !holdEn);

  // R10
  fine_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fineSel |-> holdEn);

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chanSel));

  // R4
  msb_wait_chk: assert property (@(posedge clk) disable iff (rst)
    !wrN |=> $stable(result[2*NIB_BITS-1:NIB_BITS]));

  // R3
  dac_fine_stable_chk: assert property (@(posedge clk) disable iff (rst)
    fineSel |=> $stable(dacCode));

  // R5
  fine_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fineSel) |-> (fineRun == FINE_CYCLES));
endmodule

bind hf_conv_seq hf_conv_seq_chk #(
  .NIB_BITS   (NIB_BITS),
  .CHANNELS   (CHANNELS),
  .FINE_CYCLES(FINE_CYCLES)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wrN    (wrN),
  .doneN  (doneN),
  .holdEn (holdEn),
  .fineSel(fineSel),
  .dacCode(dacCode),
  .result (result),
  .chanSel(chanSel)
);

// File: tb/hf_conv_seq_bench.sv
module hf_conv_seq_bench;
  localparam int COARSE = 4;
  localparam int FINE   = 3;
  localparam int NCH    = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrN = 1'b1;
  logic [2:0]  chanAddr = '0;
  logic [14:0] thermo;
  logic [7:0]  chanSel;
  logic        fineSel;
  logic [3:0]  dacCode;
  logic        holdEn;
  logic [7:0]  result;
  logic        doneN;
  logic        bubbleErr;

  logic [7:0]  chanVal [NCH];
  logic        forceCoarse = 1'b0;
  logic        forceFine   = 1'b0;
  logic [14:0] forceWord   = '0;
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hf_conv_seq u_hf_conv_seq (
    .clk(clk), .rst(rst), .wrN(wrN), .chanAddr(chanAddr), .thermo(thermo),
    .chanSel(chanSel), .fineSel(fineSel), .dacCode(dacCode), .holdEn(holdEn),
    .result(result), .doneN(doneN), .bubbleErr(bubbleErr)
  );

  // Comparator bank, multiplexer and residue DAC model; channel 7 is full scale
  always_comb begin
    int held;
    int lvl;
    held = 0;
    for (int i = 0; i < NCH; i++)
      if (chanSel[i]) held = (i == NCH - 1) ? 255 : int'(chanVal[i]);
    if (!fineSel) lvl = held / 16;
    else lvl = held - 16 * int'(dacCode);
    if (lvl < 0) lvl = 0;
    if (lvl > 15) lvl = 15;
    thermo = 15'((32'd1 << lvl) - 32'd1);
    if (forceCoarse && !fineSel) thermo = forceWord;
    if (forceFine && fineSel) thermo = forceWord;
  end

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic convert(input int ch, input int lowCycles, input int expRes, input bit expBub);
    bit seen;
    @(negedge clk);
    chanAddr = 3'(ch);
    wrN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(holdEn && doneN, $sformatf("R2 start: hold=%0b done=%0b expected 1/1", holdEn, doneN));
    chanAddr = 3'(ch ^ 3);
    repeat (lowCycles) @(negedge clk);
    wrN = 1'b1;
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (!doneN) seen = 1;
    end
    check(seen, "R5 done timeout: got none expected doneN low");
    check(int'(result) == expRes,
      $sformatf("R6 ch %0d result got %0d expected %0d", ch, result, expRes));
    check(chanSel == 8'(1 << ch),
      $sformatf("R7 ch %0d chanSel got %b expected %b", ch, chanSel, 8'(1 << ch)));
    check(bubbleErr == expBub,
      $sformatf("R8 bubbleErr got %0b expected %0b", bubbleErr, expBub));
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) chanVal[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(result == 0 && dacCode == 0 && chanSel == 0 && !bubbleErr && !holdEn && !fineSel && doneN,
      $sformatf("R1 reset: result=%0d dac=%0d sel=%b bub=%0b hold=%0b fine=%0b done=%0b expected 0s,done=1",
                result, dacCode, chanSel, bubbleErr, holdEn, fineSel, doneN));

    // Directed timing conversion: channel 2, level 0xC5
    chanVal[2] = 8'hC5;
    chanAddr = 3'd2;
    wrN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(holdEn && doneN, $sformatf("R2 hold=%0b done=%0b expected 1/1", holdEn, doneN));
    repeat (COARSE - 1) @(posedge clk);
    @(negedge clk);
    check(dacCode == 4'h0, $sformatf("R3 early dacCode got %h expected 0", dacCode));
    @(posedge clk);
    @(negedge clk);
    check(dacCode == 4'hC, $sformatf("R3 dacCode got %h expected c", dacCode));
    check(result == 8'h00, $sformatf("R4 result before release got %h expected 00", result));
    repeat (3) @(negedge clk);
    check(result == 8'h00, $sformatf("R4 result while wrN low got %h expected 00", result));
    wrN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(result == 8'hC0, $sformatf("R4 msb load got %h expected c0", result));
    check(fineSel && doneN, $sformatf("R10 fineSel=%0b done=%0b expected 1/1", fineSel, doneN));
    wrN = 1'b0;                       // R9 stray write inside fine phase
    @(negedge clk);
    wrN = 1'b1;
    repeat (FINE - 2) @(posedge clk);
    @(negedge clk);
    check(doneN, $sformatf("R5 early doneN got %0b expected 1", doneN));
    @(posedge clk);
    @(negedge clk);
    check(!doneN && !holdEn && !fineSel && result == 8'hC5,
      $sformatf("R5 end: done=%0b hold=%0b fine=%0b result=%h expected 0/0/0/c5",
                doneN, holdEn, fineSel, result));
    repeat (3) @(negedge clk);
    check(!holdEn && !doneN, $sformatf("R9 after stray write hold=%0b done=%0b expected 0/0", holdEn, doneN));

    // R8 bubble in coarse word: bits 0,1,2,4,6 -> code 7
    chanVal[1] = 8'h7A;
    forceWord = 15'h0057;
    forceCoarse = 1'b1;
    convert(1, 6, 8'h7A, 1'b1);
    forceCoarse = 1'b0;
    // R8 bubble in fine word: bits 0,14 -> code 15
    chanVal[1] = 8'h30;
    forceWord = 15'h4001;
    forceFine = 1'b1;
    convert(1, 2, 8'h3F, 1'b1);
    forceFine = 1'b0;
    // R8 flag clears at the next start
    convert(1, 2, 8'h30, 1'b0);

    // R6 / R7 sweep of every level on every channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int v = 0; v < 256; v++) begin
        for (int i = 0; i < NCH; i++) chanVal[i] = ~8'(v);
        chanVal[ch] = 8'(v);
        convert(ch, v % 8, (ch == NCH - 1) ? 255 : v, 1'b0);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule